// File: doc/BRIEF.md
# Branch Trace Message Generator

This block sits beside a processor pipeline and turns its stream of retired instructions into compact program-trace messages for a downstream message packer. Addresses are not reported for every instruction. The block reports only changes of flow, and it keeps a count of the instructions retired since the last message.

A direct branch produces a message that holds only that count. The target of a direct branch can be found in the program image, so no address is sent. An indirect branch, an interrupt or an exception produces a message that holds the count and the destination address, and that destination becomes the new reference address. A synchronization message holds a full absolute address. It sets the reference when trace starts, when the counter reaches its ceiling, and after a message is lost because the output queue was full.

The control is a three-state machine:
- `S_OFF`: trace disabled.
- `S_RESYNC`: the next retirement must produce a sync message.
- `S_TRACK`: normal compression.

Its transitions are:
- OFF→RESYNC: trace enabled.
- RESYNC→TRACK: sync message accepted.
- TRACK→RESYNC: message dropped because the queue was full.
- any→OFF: trace disabled.

Top module: `btm_gen`

## Requirements
- R1: After reset `msg_valid` is 0, `ref_addr` is 0 and the generator is in `S_OFF`.
- R2: While `trace_en` is 0 no message is produced and the instruction count is held at zero. The first cycle with `trace_en` high only moves the generator to `S_RESYNC`. The first retirement after that produces a sync message (transfer code 9). Its address is `ret_pc` for a sequential instruction and `ret_target` for any change of flow.
- R3: In `S_TRACK`, a sequential retirement (`ret_kind` 0) produces no message unless R7 applies, and it raises the count by one.
- R4: A direct branch (`ret_kind` 1) in `S_TRACK` produces transfer code 3. Its count is the number of instructions retired since the previous message, including the branch. Its address field is 0, and `ref_addr` does not change.
- R5: An indirect branch (`ret_kind` 2) or an interrupt/exception (`ret_kind` 3) in `S_TRACK` produces transfer code 4, with the count as in R4 and the address equal to `ret_target`.
- R6: After every accepted message the count restarts from zero, so the next message counts from 1.
- R7: In `S_TRACK`, a sequential retirement that brings the 8-bit count to 255 produces a sync message with count 255 and address `ret_pc`.
- R8: If a message is due while `out_ready` is 0, no message is produced. The count keeps rising and saturates at 255, and the next retirement produces a sync message whose count includes the lost instructions.
- R9: A message appears as a one-cycle `msg_valid` pulse in the cycle after the retirement that caused it.
- R10: Every sync message and every code-4 message loads its address into `ref_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Program trace enable |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_kind | input | 2 | 0 sequential, 1 direct branch, 2 indirect branch, 3 interrupt/exception |
| ret_pc | input | 32 | Address of the retiring instruction |
| ret_target | input | 32 | Destination address of a change of flow |
| out_ready | input | 1 | Output queue can take a message this cycle |
| msg_valid | output | 1 | Message pulse |
| msg_tcode | output | 6 | Transfer code: 3 direct, 4 indirect, 9 sync |
| msg_count | output | 8 | Instructions since the previous message, including the current one |
| msg_addr | output | 32 | Absolute address (0 for direct messages) |
| ref_addr | output | 32 | Current reference address |

## Verification
The bench targets the following corner cases:
- The count ceiling. A generator that wraps at 255 would send a small count instead of a sync at 255.
- A queue-full drop. A design that cleared the count on a drop, or that resumed direct messages afterwards, would lose instructions or leave the reference stale.
- The enable edge. A design that emitted a direct or indirect message as the first message after enabling would give the host no anchor.
- Changes of flow that arrive while a resync is pending. These must send the destination as an absolute sync address, not `ret_pc`.

// File: rtl/btm_pkg.sv
package btm_pkg;
    typedef enum logic [1:0] {
        K_SEQ      = 2'd0,
        K_DIRECT   = 2'd1,
        K_INDIRECT = 2'd2,
        K_EXCEPT   = 2'd3
    } cof_kind_e;

    typedef enum logic [1:0] {
        S_OFF,
        S_RESYNC,
        S_TRACK
    } trc_state_e;

    localparam int TCODE_W = 6;
    localparam logic [TCODE_W-1:0] TC_DIRECT   = 6'd3;
    localparam logic [TCODE_W-1:0] TC_INDIRECT = 6'd4;
    localparam logic [TCODE_W-1:0] TC_SYNC     = 6'd9;
endpackage

// File: rtl/btm_counter.sv
module btm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_comb begin
        cnt_inc = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt_inc;
    end
endmodule

// File: rtl/btm_msg_reg.sv
module btm_msg_reg
    import btm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               upd_ref,
    input  logic [TCODE_W-1:0] tcode_in,
    input  logic [CNT_W-1:0]   count_in,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic               msg_valid,
    output logic [TCODE_W-1:0] msg_tcode,
    output logic [CNT_W-1:0]   msg_count,
    output logic [ADDR_W-1:0]  msg_addr,
    output logic [ADDR_W-1:0]  ref_addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            msg_tcode <= '0;
            msg_count <= '0;
            msg_addr  <= '0;
            ref_addr  <= '0;
        end else begin
            msg_valid <= load;
            if (load) begin
                msg_tcode <= tcode_in;
                msg_count <= count_in;
                msg_addr  <= addr_in;
                if (upd_ref) ref_addr <= addr_in;
            end
        end
    end

    a_r10_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_tcode != TC_DIRECT) |-> ref_addr == msg_addr);
    a_r4_direct_keeps_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_tcode == TC_DIRECT) |-> $stable(ref_addr));
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> msg_count != '0);
endmodule

// File: rtl/btm_gen.sv
module btm_gen
    import btm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trace_en,
    input  logic               ret_valid,
    input  logic [1:0]         ret_kind,
    input  logic [ADDR_W-1:0]  ret_pc,
    input  logic [ADDR_W-1:0]  ret_target,
    input  logic               out_ready,
    output logic               msg_valid,
    output logic [TCODE_W-1:0] msg_tcode,
    output logic [CNT_W-1:0]   msg_count,
    output logic [ADDR_W-1:0]  msg_addr,
    output logic [ADDR_W-1:0]  ref_addr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    trc_state_e state_q, state_d;
    cof_kind_e  kind;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    logic want_msg, want_sync, accepted, is_cof, hit_max;
    logic [TCODE_W-1:0] tcode;
    logic [ADDR_W-1:0]  addr;

    assign kind     = cof_kind_e'(ret_kind);
    assign is_cof   = (kind != K_SEQ);
    assign hit_max  = (cnt_inc == CNT_MAX);
    assign accepted = want_msg && out_ready;

    btm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!trace_en || accepted),
        .inc     (ret_valid && state_q != S_OFF),
        .cnt     (cnt_q),
        .cnt_inc (cnt_inc)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // Next state and message decisions
    always_comb begin
        state_d   = state_q;
        want_msg  = 1'b0;
        want_sync = 1'b0;
        unique case (state_q)
            S_OFF: begin
                state_d = S_RESYNC;
            end
            S_RESYNC: begin
                want_msg  = ret_valid;
                want_sync = 1'b1;
                if (ret_valid && out_ready) state_d = S_TRACK;
            end
            S_TRACK: begin
                want_msg  = ret_valid && (is_cof || hit_max);
                want_sync = !is_cof;
                if (want_msg && !out_ready) state_d = S_RESYNC;
            end
            default: state_d = S_OFF;
        endcase
        if (!trace_en) begin
            state_d  = S_OFF;
            want_msg = 1'b0;
        end
    end

    // Message formation
    always_comb begin
        if (want_sync) begin
            tcode = TC_SYNC;
            addr  = is_cof ? ret_target : ret_pc;
        end else if (kind == K_DIRECT) begin
            tcode = TC_DIRECT;
            addr  = '0;
        end else begin
            tcode = TC_INDIRECT;
            addr  = ret_target;
        end
    end

    btm_msg_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accepted),
        .upd_ref   (tcode != TC_DIRECT),
        .tcode_in  (tcode),
        .count_in  (cnt_inc),
        .addr_in   (addr),
        .msg_valid (msg_valid),
        .msg_tcode (msg_tcode),
        .msg_count (msg_count),
        .msg_addr  (msg_addr),
        .ref_addr  (ref_addr)
    );

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> msg_valid);
    a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (want_msg && !out_ready) |=> !msg_valid);
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> (!msg_valid && state_q == S_OFF && cnt_q == '0));
    a_r6_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> cnt_q == '0);
    a_r2_first_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESYNC && accepted) |=> msg_tcode == TC_SYNC);
endmodule

// File: tb/btm_gen_tb.sv
module btm_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_kind = 2'd0;
    logic [31:0] ret_pc = '0;
    logic [31:0] ret_target = '0;
    logic        out_ready = 1'b1;
    logic        msg_valid;
    logic [5:0]  msg_tcode;
    logic [7:0]  msg_count;
    logic [31:0] msg_addr;
    logic [31:0] ref_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // model state: 0 off, 1 resync, 2 track
    int          m_st = 0;
    int          m_cnt = 0;
    logic [31:0] m_ref = '0;
    bit          e_v = 0;
    int          e_tc = 0;
    int          e_cnt = 0;
    logic [31:0] e_addr = '0;
    string       e_tag = "R9";

    always #2 clk = ~clk;

    btm_gen u_dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .ret_valid(ret_valid),
        .ret_kind(ret_kind), .ret_pc(ret_pc), .ret_target(ret_target),
        .out_ready(out_ready), .msg_valid(msg_valid), .msg_tcode(msg_tcode),
        .msg_count(msg_count), .msg_addr(msg_addr), .ref_addr(ref_addr)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int tc);
        if (tc == 3) return "R4";
        if (tc == 4) return "R5";
        return "R7";
    endfunction

    // compare outputs against the expectation from the previous cycle
    task automatic check_out(input string vtag);
        chk(msg_valid == e_v, vtag, msg_valid, e_v);
        if (e_v) begin
            chk(msg_tcode == e_tc[5:0], tag_of(e_tc), msg_tcode, e_tc);
            chk(msg_count == e_cnt[7:0], "R6", msg_count, e_cnt);
            chk(msg_addr == e_addr, tag_of(e_tc), msg_addr, e_addr);
        end
        chk(ref_addr == m_ref, "R10", ref_addr, m_ref);
    endtask

    task automatic model(input bit en, input bit rv, input int kind,
                         input logic [31:0] pc, input logic [31:0] tgt, input bit rdy);
        int c1;
        bit sync, emit;
        e_v = 0;
        if (!en) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            m_st = 1;
        end else if (rv) begin
            c1 = (m_cnt == 255) ? 255 : m_cnt + 1;
            sync = (m_st == 1) || (kind == 0 && c1 == 255);
            emit = sync || kind != 0;
            if (emit && rdy) begin
                e_v = 1;
                e_cnt = c1;
                if (sync) begin
                    e_tc = 9; e_addr = (kind == 0) ? pc : tgt;
                end else if (kind == 1) begin
                    e_tc = 3; e_addr = '0;
                end else begin
                    e_tc = 4; e_addr = tgt;
                end
                if (e_tc != 3) m_ref = e_addr;
                m_cnt = 0;
                m_st = 2;
            end else begin
                m_cnt = c1;
                if (emit) m_st = 1;
            end
        end
    endtask

    task automatic cyc(input bit en, input bit rv, input int kind,
                       input logic [31:0] pc, input logic [31:0] tgt, input bit rdy,
                       input string vtag);
        @(negedge clk);
        check_out(e_tag);
        trace_en = en; ret_valid = rv; ret_kind = kind[1:0];
        ret_pc = pc; ret_target = tgt; out_ready = rdy;
        model(en, rv, kind, pc, tgt, rdy);
        e_tag = vtag;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(msg_valid == 1'b0, "R1", msg_valid, 0);
        chk(ref_addr == 32'd0, "R1", ref_addr, 0);

        // R2: retirements while disabled produce nothing
        for (int i = 0; i < 4; i++) cyc(0, 1, i % 4, 32'h40 + i, 32'h900, 1, "R2");
        // enable: setup cycle, then first retirement gives sync at ret_pc
        cyc(1, 0, 0, 0, 0, 1, "R2");
        cyc(1, 1, 0, 32'h100, 32'h0, 1, "R2");
        // R3 sequential retirements, then R4 direct with count 4
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 32'h104 + 4*i, 0, 1, "R3");
        cyc(1, 1, 1, 32'h110, 32'h200, 1, "R4");
        // R5 indirect then exception; R6 counts restart from 1
        cyc(1, 1, 0, 32'h200, 0, 1, "R3");
        cyc(1, 1, 2, 32'h204, 32'h3000, 1, "R5");
        cyc(1, 1, 3, 32'h3000, 32'h80, 1, "R6");
        // R7 ceiling: 255th sequential retirement gives sync count 255
        for (int i = 0; i < 255; i++) cyc(1, 1, 0, 32'h80 + 4*i, 0, 1, "R7");
        // R8 drop: direct branch with queue full, then sync with count 2
        cyc(1, 1, 1, 32'h500, 32'h600, 0, "R7");
        cyc(1, 1, 0, 32'h600, 0, 1, "R8");
        // R8 change of flow while resync pending: sync to target
        cyc(1, 1, 1, 32'h604, 32'h700, 0, "R8");
        cyc(1, 1, 2, 32'h700, 32'hABC0, 1, "R8");
        // R8 saturation: many drops with queue full then accept
        for (int i = 0; i < 300; i++) cyc(1, 1, 0, 32'h1000 + 4*i, 0, 0, "R8");
        cyc(1, 1, 0, 32'h2000, 0, 1, "R8");
        // disable mid-stream
        cyc(0, 1, 2, 32'h2004, 32'h10, 1, "R8");
        cyc(0, 1, 1, 32'h2008, 32'h10, 1, "R2");

        // constrained random mixture
        for (int i = 0; i < 4000; i++) begin
            bit en, rv, rdy;
            int kind, r;
            en  = ($urandom % 100) < 97;
            rv  = ($urandom % 100) < 75;
            rdy = ($urandom % 100) < 85;
            r = $urandom % 100;
            kind = (r < 70) ? 0 : (r < 82) ? 1 : (r < 94) ? 2 : 3;
            cyc(en, rv, kind, $urandom, $urandom, rdy, "R9");
        end
        @(negedge clk);
        check_out(e_tag);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule